// File: doc/BRIEF.md
# Minimal Stored-Program Register Processor

This block is a small multi-cycle processor. It fetches 16-bit instructions from one synchronous memory that holds both code and data. It decodes each instruction and executes it, and then starts again with the next fetch. It keeps four 8-bit general-purpose registers (r0 to r3), an 8-bit program counter and a 16-bit instruction register. Data values occupy the low byte of a 16-bit memory word.

Conditions do not set flags. A compare writes zero into r0 when its first register is greater than its second. A later jump tests r0 for zero and takes its target from a register. A separate branch compares two registers directly and takes its target from the instruction. A halt instruction stops all memory activity and raises the halt output until the next reset.

Instruction layout: the opcode is in bits 15:12. Register field A is in bits 11:10, B in bits 9:8 and C in bits 7:6. The 8-bit address or constant is in bits 7:0, and the rotate amount is in bits 2:0.

Top module: `stored_prog_cpu`

## Requirements
- R1: While `rst` is high the program counter and all four registers are cleared, `halt` and `mem_we` are low, and the first fetch after reset reads address 0.
- R2: Each instruction begins with a cycle that drives the program counter on `mem_addr`. The word read arrives one cycle later and is captured into the instruction register. The program counter then increments by one. Execution follows in the next cycle. Every instruction takes 3 cycles, except a load, which takes 4.
- R3: Load (opcode 1) drives address bits 7:0 in its execute cycle and writes the low byte of the returned word into register A one cycle later. Load immediate (opcode 2) writes bits 7:0 into register A.
- R4: Store (opcode 3) asserts `mem_we` for exactly its execute cycle. During that cycle `mem_addr` carries bits 7:0 and `mem_wdata` carries register A zero-extended to 16 bits.
- R5: Add (opcode 4) writes (B + C) modulo 256 into register A.
- R6: AND, OR and XOR (opcodes 5, 6, 7) write the bitwise result of B and C into register A.
- R7: Rotate right (opcode 8) writes B rotated right by bits 2:0 into register A, so that 0x65 rotated by one gives 0xB2.
- R8: Compare (opcode 9) writes 0 into r0 when register A is greater than register B, both taken as unsigned. Otherwise r0 keeps its value.
- R9: Jump (opcode 10) loads the program counter from register A when r0 is zero. Otherwise execution continues at the next address.
- R10: Branch (opcode 11) loads the program counter from bits 7:0 when register A is greater than register B, both unsigned. Otherwise execution continues at the next address.
- R11: Halt (opcode 15) raises `halt` one cycle after its execute cycle. It then holds `halt` high with `mem_we` low and performs no further fetch until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| halt | output | 1 | Processor stopped |

## Verification
A fetch address is due in the first cycle of each instruction. The captured instruction takes effect two cycles later, in the execute cycle. A store's address and data are therefore due in that execute cycle, and load data reaches its register one cycle after it. The halt output is due one cycle after the halt instruction executes, which is cycle 83 after reset for the test program.

The bench steps a behavioural instruction model once per clock and compares the memory port and halt against it on every falling edge, away from the edges where the design updates. Memory contents are checked after the program has stopped, and so is the cycle in which halt first appears.

// File: rtl/stored_prog_cpu.sv
module stored_prog_cpu #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          mem_we,
  input  logic [15:0]   mem_rdata,
  output logic          halt
);
  localparam int IW   = 16;
  localparam int NREG = 4;

  typedef enum logic [2:0] {S_FETCH, S_FCAP, S_EXEC, S_LCAP, S_HALT} st_t;

  localparam logic [3:0] OP_LD  = 4'd1, OP_LDI = 4'd2, OP_ST  = 4'd3,
                         OP_ADD = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6,
                         OP_XOR = 4'd7, OP_ROR = 4'd8, OP_CMP = 4'd9,
                         OP_JMP = 4'd10, OP_BR = 4'd11, OP_HLT = 4'd15;

  st_t            state;
  logic [AW-1:0]  pc;
  logic [IW-1:0]  ir;
  logic [DW-1:0]  rf [NREG];

  logic [3:0]     op;
  logic [1:0]     fa, fb, fc;
  logic [DW-1:0]  va, vb, vc, alu;
  logic [2*DW-1:0] rot;
  logic           a_gt_b;

  assign op     = ir[15:12];
  assign fa     = ir[11:10];
  assign fb     = ir[9:8];
  assign fc     = ir[7:6];
  assign va     = rf[fa];
  assign vb     = rf[fb];
  assign vc     = rf[fc];
  assign a_gt_b = va > vb;
  assign rot    = {vb, vb} >> ir[2:0];

  always_comb begin
    case (op)
      OP_ADD:  alu = vb + vc;
      OP_AND:  alu = vb & vc;
      OP_OR:   alu = vb | vc;
      OP_XOR:  alu = vb ^ vc;
      default: alu = rot[DW-1:0];
    endcase
  end

  assign mem_we    = (state == S_EXEC) && (op == OP_ST);
  assign mem_addr  = ((state == S_EXEC) && (op == OP_LD || op == OP_ST)) ? ir[AW-1:0] : pc;
  assign mem_wdata = {{(IW-DW){1'b0}}, va};
  assign halt      = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_FETCH: state <= S_FCAP;
        S_FCAP: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (op)
            OP_LD:  state <= S_LCAP;
            OP_LDI: rf[fa] <= ir[DW-1:0];
            OP_ADD, OP_AND, OP_OR, OP_XOR, OP_ROR: rf[fa] <= alu;
            OP_CMP: if (a_gt_b) rf[0] <= '0;
            OP_JMP: if (rf[0] == '0) pc <= va[AW-1:0];
            OP_BR:  if (a_gt_b) pc <= ir[AW-1:0];
            OP_HLT: state <= S_HALT;
            default: ;
          endcase
        end
        S_LCAP: begin
          rf[fa] <= mem_rdata[DW-1:0];
          state  <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && state == S_FETCH && !halt));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FCAP) |=> (pc == $past(pc) + 1'b1 && state == S_EXEC));

  assert_store_single_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_cmp_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op == OP_CMP && !a_gt_b) |=> rf[0] == $past(rf[0]));

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && !mem_we && $stable(pc)));
endmodule

// File: tb/stored_prog_cpu_tb.sv
module stored_prog_cpu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        halt;

  int vectors = 0;
  int fails   = 0;

  logic [15:0] mem [256];
  int          mmem [256];
  int          mr [4];
  int          mpc, mir, mph;

  always #10 clk = ~clk;

  stored_prog_cpu u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halt(halt)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(input int a, input int w);
    mem[a]  = w[15:0];
    mmem[a] = w;
  endtask

  task automatic compare_cycle();
    int op, imm;
    op  = (mir >> 12) & 15;
    imm = mir & 255;
    case (mph)
      0: begin
        chk("R2 fetch addr", int'(mem_addr), mpc);
        chk("R2 fetch we", int'(mem_we), 0);
        chk("R11 halt low", int'(halt), 0);
      end
      2: begin
        if (op == 3) begin
          chk("R4 store we", int'(mem_we), 1);
          chk("R4 store addr", int'(mem_addr), imm);
          chk("R4 store data", int'(mem_wdata), mr[(mir >> 10) & 3]);
        end else begin
          chk("R4 no write", int'(mem_we), 0);
          if (op == 1) chk("R3 load addr", int'(mem_addr), imm);
        end
      end
      4: begin
        chk("R11 halt high", int'(halt), 1);
        chk("R11 quiet", int'(mem_we), 0);
      end
      default: chk("R2 capture we", int'(mem_we), 0);
    endcase
  endtask

  task automatic advance();
    int op, a, b, c, imm, sh;
    op  = (mir >> 12) & 15;
    a   = (mir >> 10) & 3;
    b   = (mir >> 8) & 3;
    c   = (mir >> 6) & 3;
    imm = mir & 255;
    sh  = mir & 7;
    case (mph)
      0: mph = 1;
      1: begin mir = mmem[mpc]; mpc = (mpc + 1) & 255; mph = 2; end
      2: begin
        mph = 0;
        case (op)
          1:  mph = 3;
          2:  mr[a] = imm;
          3:  mmem[imm] = mr[a];
          4:  mr[a] = (mr[b] + mr[c]) & 255;
          5:  mr[a] = mr[b] & mr[c];
          6:  mr[a] = mr[b] | mr[c];
          7:  mr[a] = mr[b] ^ mr[c];
          8:  mr[a] = ((mr[b] >> sh) | (mr[b] << (8 - sh))) & 255;
          9:  if (mr[a] > mr[b]) mr[0] = 0;
          10: if (mr[0] == 0) mpc = mr[a];
          11: if (mr[a] > mr[b]) mpc = imm;
          15: mph = 4;
          default: ;
        endcase
      end
      3: begin mr[a] = mmem[imm] & 255; mph = 0; end
      default: mph = 4;
    endcase
  endtask

  initial begin
    int cyc, halt_seen, after;
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; mmem[i] = 0; end
    for (int i = 0; i < 4; i++) mr[i] = 0;
    mpc = 0; mir = 0; mph = 0;
    put(8'h00, 16'h2465); put(8'h01, 16'h8901); put(8'h02, 16'h3880);
    put(8'h03, 16'h1490); put(8'h04, 16'h1C91); put(8'h05, 16'h49C0);
    put(8'h06, 16'h3881); put(8'h07, 16'h51C0); put(8'h08, 16'h3082);
    put(8'h09, 16'h61C0); put(8'h0A, 16'h3083); put(8'h0B, 16'h71C0);
    put(8'h0C, 16'h3084); put(8'h0D, 16'h9D00); put(8'h0E, 16'h3085);
    put(8'h0F, 16'h2C18); put(8'h10, 16'hAC00); put(8'h11, 16'h3086);
    put(8'h12, 16'h9900); put(8'h13, 16'hAC00); put(8'h14, 16'h3487);
    put(8'h18, 16'hB620); put(8'h19, 16'h3488); put(8'h1A, 16'hB920);
    put(8'h1B, 16'h3489); put(8'h20, 16'h20FF); put(8'h21, 16'h4000);
    put(8'h22, 16'h308A); put(8'h23, 16'hF000); put(8'h24, 16'h308B);
    put(8'h90, 16'h0007); put(8'h91, 16'h0005);

    repeat (3) @(negedge clk);
    chk("R1 reset halt", int'(halt), 0);
    chk("R1 reset we", int'(mem_we), 0);
    chk("R1 reset addr", int'(mem_addr), 0);
    rst = 1'b0;

    halt_seen = -1;
    after = 0;
    for (cyc = 0; cyc < 2000 && after < 10; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (halt && halt_seen < 0) halt_seen = cyc;
      compare_cycle();
      advance();
      if (mph == 4) after++;
    end
    if (after < 10) begin
      fails++;
      $display("FAIL R11 watchdog: actual running expected halted");
    end

    chk("R2 halt cycle", halt_seen, 83);
    chk("R7 ror 0x65", int'(mem[8'h80]), 8'hB2);
    chk("R5 add via loads R3", int'(mem[8'h81]), 8'h0C);
    chk("R6 and", int'(mem[8'h82]), 8'h05);
    chk("R6 or", int'(mem[8'h83]), 8'h07);
    chk("R6 xor", int'(mem[8'h84]), 8'h02);
    chk("R8 cmp false keeps r0", int'(mem[8'h85]), 8'h02);
    chk("R9 jump not taken", int'(mem[8'h86]), 8'h02);
    chk("R9 jump taken skips", int'(mem[8'h87]), 0);
    chk("R10 branch not taken", int'(mem[8'h88]), 8'h07);
    chk("R10 branch taken skips", int'(mem[8'h89]), 0);
    chk("R5 add wraps", int'(mem[8'h8A]), 8'hFE);
    chk("R11 nothing after halt", int'(mem[8'h8B]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule